// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block holds the single atomic reservation of one CPU for load-locked / store-conditional pairs. It works on physical addresses after translation. A locked read installs a reservation covering the 16-byte granule that holds its address and sets a valid flag. A conditional store is judged against that reservation. The block returns a result code and tells the pipeline whether the store may go on to the memory system. A coherence snoop that touches the reserved granule cancels the reservation.

Uncacheable conditional stores are mailbox-style accesses. They skip the reservation check, always go out to memory, and carry a distinct result code so that the result register is left alone. The block also counts failed conditional stores in a row. Each time that count reaches another whole multiple of a programmable interval, it emits a one-cycle warning tagged with the CPU identifier, which helps spot livelock. The count saturates instead of wrapping, and a passing store clears it.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A locked read (`lr_valid`) records `lr_paddr` with its low 4 bits ignored as the reservation and sets the reservation flag. A later cacheable conditional store to any byte of that 16-byte granule passes.
- R2: A cacheable conditional store fails when the reservation flag is clear, or when its address bits above bit 3 differ from the recorded reservation.
- R3: A failing store returns `resp_code` 0 with `resp_issue` low and clears the reservation flag.
- R4: An uncacheable conditional store (`sc_uncached` high) returns `resp_code` 2 with `resp_issue` high. It leaves both the reservation flag and the failure count unchanged.
- R5: A passing cacheable store returns `resp_code` 1 with `resp_issue` high, clears the reservation flag, and resets the failure count to zero.
- R6: Each failing store adds one to the failure count. When the new count is a nonzero multiple of `WARN_INTERVAL`, `warn_pulse` is high for exactly one cycle, and `warn_cpu_id` carries the `cpu_id` sampled with that store.
- R7: A snoop (`snp_valid`) whose address lies in the reserved granule clears the reservation flag. A snoop to any other granule has no effect.
- R8: A locked read wins over a snoop or a conditional store in the same cycle, and the new reservation stays valid. A conditional store in the same cycle as a locked read is judged against the reservation that held before that cycle.
- R9: Reset (`rst_n` low) clears the reservation flag, the reservation address, the failure count and all outputs.
- R10: The failure count saturates at its all-ones value. Failures past saturation raise no further warnings.
- R11: Outputs are registered. `resp_valid` is high exactly in the cycle after a cycle with `sc_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_id | input | CPU_ID_W | Identifier of the owning CPU |
| lr_valid | input | 1 | Locked-read request |
| lr_paddr | input | PADDR_W | Physical address of the locked read |
| sc_valid | input | 1 | Conditional-store request |
| sc_paddr | input | PADDR_W | Physical address of the conditional store |
| sc_uncached | input | 1 | Conditional store targets uncacheable space |
| snp_valid | input | 1 | Coherence invalidate snoop |
| snp_paddr | input | PADDR_W | Physical address of the snoop |
| resp_valid | output | 1 | Conditional-store decision valid |
| resp_issue | output | 1 | Store may be forwarded to memory |
| resp_code | output | 2 | 0 fail, 1 pass, 2 uncacheable mailbox |
| warn_pulse | output | 1 | One-cycle livelock warning |
| warn_cpu_id | output | CPU_ID_W | CPU identifier attached to the warning |

## Verification
Conditional stores are sent with the reservation clear, to the same granule at a different byte offset, and to the next granule up. These three cases separate the flag test from the granule compare and show the masking width. Uncacheable stores are placed between cacheable failures and ahead of a cacheable store that should pass, which shows that they neither consume the reservation nor disturb the failure count. Snoops to the reserved granule and to its neighbour, and locked reads that coincide with a snoop or with a store, pin down the update order inside one cycle. Long runs of failures, broken by a pass or a reset and then pushed past saturation, expose off-by-one errors in the warning interval and counter wraparound.

// File: rtl/llsc_resv_pkg.sv
package llsc_resv_pkg;

  typedef enum logic [1:0] {
    SC_FAIL    = 2'd0,
    SC_PASS    = 2'd1,
    SC_MAILBOX = 2'd2
  } sc_code_e;

endpackage

// File: rtl/llsc_resv_store.sv
module llsc_resv_store #(
  parameter int PADDR_W   = 40,
  parameter int GRAN_BITS = 4,
  localparam int TAG_W    = PADDR_W - GRAN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_valid,
  input  logic [PADDR_W-1:0] lr_paddr,
  input  logic             consume,
  input  logic             snp_valid,
  input  logic [PADDR_W-1:0] snp_paddr,
  output logic             resv_valid,
  output logic [TAG_W-1:0] resv_tag
);

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             snp_hit;
  logic             upd_en;

  assign snp_hit = snp_valid && valid_q && (snp_paddr[PADDR_W-1:GRAN_BITS] == tag_q);

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    if (consume) valid_d = 1'b0;
    if (snp_hit) valid_d = 1'b0;
    if (lr_valid) begin
      valid_d = 1'b1;
      tag_d   = lr_paddr[PADDR_W-1:GRAN_BITS];
    end
  end

  assign upd_en = lr_valid | consume | snp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
    end
  end

  assign resv_valid = valid_q;
  assign resv_tag   = tag_q;

  p_lr_install_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lr_valid |=> (resv_valid && resv_tag == $past(lr_paddr[PADDR_W-1:GRAN_BITS])));

  p_lr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && (snp_valid || consume)) |=> resv_valid);

  p_snoop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && resv_valid && !lr_valid &&
     snp_paddr[PADDR_W-1:GRAN_BITS] == resv_tag) |=> !resv_valid);

  p_consume_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !lr_valid) |=> !resv_valid);

endmodule

// File: rtl/llsc_resv_check.sv
module llsc_resv_check
  import llsc_resv_pkg::*;
#(
  parameter int PADDR_W   = 40,
  parameter int GRAN_BITS = 4,
  localparam int TAG_W    = PADDR_W - GRAN_BITS
) (
  input  logic               sc_valid,
  input  logic [PADDR_W-1:0] sc_paddr,
  input  logic               sc_uncached,
  input  logic               resv_valid,
  input  logic [TAG_W-1:0]   resv_tag,
  output sc_code_e           code,
  output logic               issue,
  output logic               consume,
  output logic               pass_evt,
  output logic               fail_evt
);

  logic tag_match;

  assign tag_match = (sc_paddr[PADDR_W-1:GRAN_BITS] == resv_tag);

  always_comb begin
    code     = SC_FAIL;
    issue    = 1'b0;
    consume  = 1'b0;
    pass_evt = 1'b0;
    fail_evt = 1'b0;
    if (sc_valid) begin
      if (sc_uncached) begin
        code  = SC_MAILBOX;
        issue = 1'b1;
      end else begin
        consume = 1'b1;
        if (resv_valid && tag_match) begin
          code     = SC_PASS;
          issue    = 1'b1;
          pass_evt = 1'b1;
        end else begin
          fail_evt = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/llsc_fail_track.sv
module llsc_fail_track #(
  parameter int FAIL_CNT_W    = 32,
  parameter int WARN_INTERVAL = 100000,
  localparam int PH_W         = (WARN_INTERVAL > 2) ? $clog2(WARN_INTERVAL) : 1,
  localparam bit POW2         = ((WARN_INTERVAL & (WARN_INTERVAL - 1)) == 0)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic pass_evt,
  output logic warn
);

  localparam logic [FAIL_CNT_W-1:0] CNT_MAX = '1;

  logic [FAIL_CNT_W-1:0] cnt_q, cnt_d;
  logic                  inc_evt;
  logic                  cnt_en;
  logic                  wrap_hit;
  logic                  warn_q, warn_d;

  assign inc_evt = fail_evt && !pass_evt && (cnt_q != CNT_MAX);
  assign cnt_en  = pass_evt | inc_evt;

  always_comb begin
    cnt_d = cnt_q;
    if (pass_evt)     cnt_d = '0;
    else if (inc_evt) cnt_d = cnt_q + 1'b1;
  end

  generate
    if (POW2) begin : g_pow2
      assign wrap_hit = (cnt_d[PH_W-1:0] == '0);
    end else begin : g_phase
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_INTERVAL - 1);
      logic [PH_W-1:0] ph_q, ph_d;
      always_comb begin
        ph_d = ph_q;
        if (pass_evt)     ph_d = '0;
        else if (inc_evt) ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ph_q <= '0;
        else if (cnt_en) ph_q <= ph_d;
      end
      assign wrap_hit = (ph_q == PH_LAST);
    end
  endgenerate

  assign warn_d = inc_evt && wrap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= warn_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign warn = warn_q;

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && !pass_evt && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_evt && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && !warn));

  p_pass_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> (cnt_q == '0 && !warn));

  p_warn_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn |=> !warn);

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_resv_pkg::*;
#(
  parameter int PADDR_W       = 40,
  parameter int CPU_ID_W      = 4,
  parameter int GRAN_BITS     = 4,
  parameter int FAIL_CNT_W    = 32,
  parameter int WARN_INTERVAL = 100000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_ID_W-1:0] cpu_id,
  input  logic                lr_valid,
  input  logic [PADDR_W-1:0]  lr_paddr,
  input  logic                sc_valid,
  input  logic [PADDR_W-1:0]  sc_paddr,
  input  logic                sc_uncached,
  input  logic                snp_valid,
  input  logic [PADDR_W-1:0]  snp_paddr,
  output logic                resp_valid,
  output logic                resp_issue,
  output logic [1:0]          resp_code,
  output logic                warn_pulse,
  output logic [CPU_ID_W-1:0] warn_cpu_id
);

  localparam int TAG_W = PADDR_W - GRAN_BITS;

  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;
  sc_code_e         chk_code;
  logic             chk_issue, chk_consume, chk_pass, chk_fail;
  logic             warn_evt;

  logic                valid_q;
  logic                issue_q;
  sc_code_e            code_q;
  logic [CPU_ID_W-1:0] id_q;
  logic [CPU_ID_W-1:0] id_hold_q;

  llsc_resv_store #(.PADDR_W(PADDR_W), .GRAN_BITS(GRAN_BITS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .lr_valid   (lr_valid),
    .lr_paddr   (lr_paddr),
    .consume    (chk_consume),
    .snp_valid  (snp_valid),
    .snp_paddr  (snp_paddr),
    .resv_valid (resv_valid),
    .resv_tag   (resv_tag)
  );

  llsc_resv_check #(.PADDR_W(PADDR_W), .GRAN_BITS(GRAN_BITS)) u_check (
    .sc_valid    (sc_valid),
    .sc_paddr    (sc_paddr),
    .sc_uncached (sc_uncached),
    .resv_valid  (resv_valid),
    .resv_tag    (resv_tag),
    .code        (chk_code),
    .issue       (chk_issue),
    .consume     (chk_consume),
    .pass_evt    (chk_pass),
    .fail_evt    (chk_fail)
  );

  llsc_fail_track #(.FAIL_CNT_W(FAIL_CNT_W), .WARN_INTERVAL(WARN_INTERVAL)) u_fail (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_evt (chk_fail),
    .pass_evt (chk_pass),
    .warn     (warn_evt)
  );

  // Response register: decision for the store presented in the previous cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      issue_q <= 1'b0;
      code_q  <= SC_FAIL;
    end else begin
      valid_q <= sc_valid;
      issue_q <= chk_issue;
      code_q  <= chk_code;
    end
  end

  // CPU id captured alongside each failing store, presented with the warning.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        id_hold_q <= '0;
    else if (chk_fail) id_hold_q <= cpu_id;
  end

  assign id_q = id_hold_q;

  assign resp_valid  = valid_q;
  assign resp_issue  = issue_q;
  assign resp_code   = code_q;
  assign warn_pulse  = warn_evt;
  assign warn_cpu_id = id_q;

  p_fail_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == SC_FAIL) |-> !resp_issue);

  p_mailbox_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_uncached) |=> (resp_valid && resp_issue && resp_code == SC_MAILBOX));

  p_resp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |=> resp_valid);

  p_resp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_valid |=> !resp_valid);

  p_warn_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    warn_pulse |-> (resp_valid && resp_code == SC_FAIL));

endmodule

// File: tb/tb_llsc_resv_monitor.sv
`timescale 1ns/1ps
module tb_llsc_resv_monitor;

  localparam int AW = 32;
  localparam int IW = 4;
  localparam int WI = 8;
  localparam int CW = 5;
  localparam int CMAX = 31;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [IW-1:0] cpu_id;
  logic          lr_valid, sc_valid, sc_uncached, snp_valid;
  logic [AW-1:0] lr_paddr, sc_paddr, snp_paddr;
  logic          resp_valid, resp_issue, warn_pulse;
  logic [1:0]    resp_code;
  logic [IW-1:0] warn_cpu_id;

  always #4 clk = ~clk;

  llsc_resv_monitor #(
    .PADDR_W(AW), .CPU_ID_W(IW), .GRAN_BITS(4),
    .FAIL_CNT_W(CW), .WARN_INTERVAL(WI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
    .lr_valid(lr_valid), .lr_paddr(lr_paddr),
    .sc_valid(sc_valid), .sc_paddr(sc_paddr), .sc_uncached(sc_uncached),
    .snp_valid(snp_valid), .snp_paddr(snp_paddr),
    .resp_valid(resp_valid), .resp_issue(resp_issue), .resp_code(resp_code),
    .warn_pulse(warn_pulse), .warn_cpu_id(warn_cpu_id)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Behavioural reference state
  bit m_v;
  int unsigned m_g;
  int m_cnt;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_v = 0; m_g = 0; m_cnt = 0;
  endtask

  task automatic step(input bit lr, input int unsigned lra,
                      input bit sc, input int unsigned sca, input bit unc,
                      input bit snp, input int unsigned snpa, input string tag);
    bit e_valid, e_issue, e_warn, nv;
    int e_code;
    int unsigned ng;
    @(negedge clk);
    lr_valid = lr; lr_paddr = lra;
    sc_valid = sc; sc_paddr = sca; sc_uncached = unc;
    snp_valid = snp; snp_paddr = snpa;
    e_valid = sc; e_issue = 0; e_code = 0; e_warn = 0;
    if (sc) begin
      if (unc) begin
        e_code = 2; e_issue = 1;
      end else if (m_v && (sca >> 4) == m_g) begin
        e_code = 1; e_issue = 1; m_cnt = 0;
      end else begin
        if (m_cnt < CMAX) begin
          m_cnt++;
          if (m_cnt % WI == 0) e_warn = 1;
        end
      end
    end
    nv = m_v; ng = m_g;
    if (sc && !unc) nv = 0;
    if (snp && m_v && (snpa >> 4) == m_g) nv = 0;
    if (lr) begin nv = 1; ng = lra >> 4; end
    m_v = nv; m_g = ng;
    @(posedge clk);
    #2;
    check(resp_valid == e_valid && (!e_valid || (resp_issue == e_issue && resp_code == 2'(e_code)))
          && warn_pulse == e_warn && (!e_warn || warn_cpu_id == cpu_id),
          tag,
          $sformatf("v%0d i%0d c%0d w%0d id%0d", resp_valid, resp_issue, resp_code, warn_pulse, warn_cpu_id),
          $sformatf("v%0d i%0d c%0d w%0d id%0d", e_valid, e_issue, e_code, e_warn, cpu_id));
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    lr_valid = 0; sc_valid = 0; sc_uncached = 0; snp_valid = 0;
    lr_paddr = '0; sc_paddr = '0; snp_paddr = '0;
    model_reset();
    repeat (2) @(negedge clk);
    check(resp_valid == 0 && resp_issue == 0 && resp_code == 0 && warn_pulse == 0 && warn_cpu_id == 0,
          "R9 reset outputs",
          $sformatf("v%0d i%0d c%0d w%0d id%0d", resp_valid, resp_issue, resp_code, warn_pulse, warn_cpu_id),
          "v0 i0 c0 w0 id0");
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cpu_id = 4'd5;
    model_reset();
    do_reset();

    // R9: reservation flag clear after reset
    step(0, 0, 1, 32'h0, 0, 0, 0, "R9 sc after reset fails");
    idle("R11 idle no response");

    // R1 / R5: same granule at other offset passes
    step(1, 32'h1000_0004, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 1, 32'h1000_000C, 0, 0, 0, "R1 R5 sc same granule passes");
    step(0, 0, 1, 32'h1000_0004, 0, 0, 0, "R3 R5 flag cleared after pass");

    // R2: neighbouring granule mismatch
    step(1, 32'h2000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 1, 32'h2010, 0, 0, 0, "R2 granule mismatch fails");
    step(0, 0, 1, 32'h2000, 0, 0, 0, "R3 flag cleared after fail");

    // R4: uncached bypasses and preserves flag
    step(1, 32'h3000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 1, 32'h9999, 1, 0, 0, "R4 uncached mailbox");
    step(0, 0, 1, 32'h3008, 0, 0, 0, "R4 flag kept after uncached");

    // R7: snoop in granule clears, other granule does not
    step(1, 32'h4000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 0, 0, 0, 1, 32'h400F, "R7 snoop hit");
    step(0, 0, 1, 32'h4000, 0, 0, 0, "R7 sc after snoop hit fails");
    step(1, 32'h5000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 0, 0, 0, 1, 32'h5010, "R7 snoop other granule");
    step(0, 0, 1, 32'h5004, 0, 0, 0, "R7 sc after snoop miss passes");

    // R8: same-cycle ordering
    step(1, 32'h6000, 0, 0, 0, 1, 32'h6000, "R8 lr with snoop");
    step(0, 0, 1, 32'h6000, 0, 0, 0, "R8 lr beats snoop");
    step(1, 32'h7000, 0, 0, 0, 0, 0, "R1 locked read");
    step(1, 32'h8000, 1, 32'h7000, 0, 0, 0, "R8 sc judged on old reservation");
    step(0, 0, 1, 32'h8000, 0, 0, 0, "R8 new reservation survives sc");

    // R6: warning at 8th failure, uncached interleaved (R4)
    cpu_id = 4'd9;
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 1, 32'hA000, 0, 0, 0, "R6 fail run");
      if (i == 3) step(0, 0, 1, 32'hA000, 1, 0, 0, "R4 uncached keeps count");
    end
    step(0, 0, 1, 32'hA000, 0, 0, 0, "R6 no warn after pulse");

    // R5: pass resets the count
    for (int i = 0; i < 5; i++) step(0, 0, 1, 32'hB000, 0, 0, 0, "R6 fail run");
    step(1, 32'hB000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 1, 32'hB000, 0, 0, 0, "R5 pass resets count");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 32'hB000, 0, 0, 0, "R5 R6 count from zero");

    // R9: reset mid run clears count
    for (int i = 0; i < 3; i++) step(0, 0, 1, 32'hC000, 0, 0, 0, "R6 fail run");
    do_reset();
    cpu_id = 4'd3;
    for (int i = 0; i < 9; i++) step(0, 0, 1, 32'hC000, 0, 0, 0, "R9 count cleared by reset");

    // R10: saturation
    for (int i = 0; i < 45; i++) step(0, 0, 1, 32'hD000, 0, 0, 0, "R10 saturating run");
    step(1, 32'hE000, 0, 0, 0, 0, 0, "R1 locked read");
    step(0, 0, 1, 32'hE000, 0, 0, 0, "R5 pass after saturation");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 32'hE000, 0, 0, 0, "R10 R6 warn after clear");
    idle("R11 idle no response");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule